// File: doc/BRIEF.md
# Stochastic Branch Metric Generator

This block serves one trellis section of a stochastic turbo or convolutional decoder. It takes two quantized channel probabilities, one for the systematic symbol and one for the parity symbol. Each decoding cycle it turns them into random bit streams by comparing them against fresh random vectors. It then combines those streams with the incoming extrinsic bit stream to form the four branch-metric streams. One stream exists for each pairing of information bit and parity bit.

A start pulse loads a new pair of probabilities. The block keeps them until the next start, and every clock after that is one decoding cycle. The channel probabilities arrive already scaled. The a priori term of a uniform source is equal on every branch, so it is left out. Each branch stream is a three-input AND of mutually independent streams, so the rate of ones on each output approximates the product of the three probabilities.

Top module: `sbm_branch_gen`

## Requirements
- R1: While `rst` is high, all four bits of `gamma_o` are 0 and the stored probabilities are 0.
- R2: `sys_prob` and `par_prob` are captured only on a clock edge where `start` is 1. On any other edge, a change on those inputs has no effect on later outputs.
- R3: For a 7-bit unsigned probability p and a random value r, the "value 1" stream bit is 1 exactly when r < p. The "value 0" stream bit is 1 exactly when r < 127 - p. The systematic streams use `rnd_sys` and the parity streams use `rnd_par`.
- R4: `gamma_o[2*j+k]` is the branch for information bit j and parity bit k. It equals the AND of three bits: the extrinsic bit for j (`ext_in` for j=1, its inverse for j=0), the systematic stream for j, and the parity stream for k.
- R5: `gamma_o` is registered. It reflects the inputs sampled on the previous rising edge. On an edge where `start` is 1, the newly presented probabilities are already used.
- R6: When `ext_in` is 1, bits 0 and 1 of `gamma_o` are 0 on the next cycle. When `ext_in` is 0, bits 2 and 3 are 0 on the next cycle.
- R7: Boundary values: a probability of 0 never yields a 1 on its "value 1" stream. A probability of 127 never yields a 1 on its "value 0" stream.
- R8: Suppose the random vectors are uniform over 0..127 and probabilities are held for 4096 cycles. Then the count of ones on each output stays close to 4096 times the product of the three stream probabilities. The "value 1" stream has probability p/128 and the "value 0" stream has probability (127-p)/128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one rising edge per decoding cycle |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load new channel probabilities this cycle |
| sys_prob | input | 7 | Systematic-symbol probability that the information bit is 1 |
| par_prob | input | 7 | Parity-symbol probability that the parity bit is 1 |
| ext_in | input | 1 | Incoming extrinsic stream bit for information bit 1 |
| rnd_sys | input | 7 | Random vector for the systematic comparators |
| rnd_par | input | 7 | Random vector for the parity comparators |
| gamma_o | output | 4 | Branch streams, bit 2*j+k for info bit j, parity bit k |

## Verification
Every cycle, the assertions check four things. The extrinsic bit gates off the opposite-row branches on the following cycle. The stored probabilities hold when no start is given. A systematic random value at or above the stored probability silences the "value 1" row. The outputs never carry more than two ones. The exact bit of every branch, taken cycle by cycle, is shown only by the bench's scoreboard. So are the capture-on-start and ignore-otherwise behaviour, the 0 and 127 edges, and the long-run ones counts against the product of probabilities.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
    parameter int unsigned PROB_W   = 7;
    localparam int unsigned NUM_BR  = 4;
    localparam int unsigned NUM_CH  = 2;   // channel 0 systematic, 1 parity

    function automatic int unsigned br_idx(input int unsigned info_b, input int unsigned par_b);
        return 2 * info_b + par_b;
    endfunction
endpackage

// File: rtl/sbm_stream_gen.sv
module sbm_stream_gen #(
    parameter int unsigned W = sbm_pkg::PROB_W
) (
    input  logic [W-1:0] prob,
    input  logic [W-1:0] rnd,
    output logic         bit_one,
    output logic         bit_zero
);
    localparam logic [W-1:0] FULL = '1;

    logic [W-1:0] compl_p;

    always_comb begin
        compl_p  = FULL - prob;
        bit_one  = (rnd < prob);
        bit_zero = (rnd < compl_p);
    end
endmodule

// File: rtl/sbm_branch_and.sv
module sbm_branch_and #(
    parameter int unsigned NB = sbm_pkg::NUM_BR
) (
    input  logic          ext_bit,
    input  logic [1:0]    sys_s,    // index = information bit value
    input  logic [1:0]    par_s,    // index = parity bit value
    output logic [NB-1:0] gamma
);
    logic [1:0] ext_s;
    assign ext_s = {ext_bit, ~ext_bit};

    for (genvar j = 0; j < 2; j++) begin : g_info
        for (genvar k = 0; k < 2; k++) begin : g_par
            assign gamma[sbm_pkg::br_idx(j, k)] = ext_s[j] & sys_s[j] & par_s[k];
        end
    end
endmodule

// File: rtl/sbm_branch_gen.sv
module sbm_branch_gen #(
    parameter int unsigned PROB_W = sbm_pkg::PROB_W,
    parameter int unsigned NUM_BR = sbm_pkg::NUM_BR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PROB_W-1:0] sys_prob,
    input  logic [PROB_W-1:0] par_prob,
    input  logic              ext_in,
    input  logic [PROB_W-1:0] rnd_sys,
    input  logic [PROB_W-1:0] rnd_par,
    output logic [NUM_BR-1:0] gamma_o
);
    localparam int unsigned NCH = sbm_pkg::NUM_CH;

    typedef struct packed {
        logic [PROB_W-1:0] sys_p;
        logic [PROB_W-1:0] par_p;
        logic [NUM_BR-1:0] gamma;
    } state_t;

    state_t state_d, state_q;

    logic [PROB_W-1:0] eff_p   [NCH];
    logic [PROB_W-1:0] rnd_v   [NCH];
    logic [NCH-1:0]    s_one, s_zero;
    logic [NUM_BR-1:0] gamma_c;

    // Probabilities in force this cycle: new ones on a start edge.
    always_comb begin
        eff_p[0] = start ? sys_prob : state_q.sys_p;
        eff_p[1] = start ? par_prob : state_q.par_p;
        rnd_v[0] = rnd_sys;
        rnd_v[1] = rnd_par;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        sbm_stream_gen #(.W(PROB_W)) u_gen (
            .prob     (eff_p[c]),
            .rnd      (rnd_v[c]),
            .bit_one  (s_one[c]),
            .bit_zero (s_zero[c])
        );
    end

    sbm_branch_and #(.NB(NUM_BR)) u_and (
        .ext_bit (ext_in),
        .sys_s   ({s_one[0], s_zero[0]}),
        .par_s   ({s_one[1], s_zero[1]}),
        .gamma   (gamma_c)
    );

    always_comb begin
        state_d       = state_q;
        state_d.gamma = gamma_c;
        if (start) begin
            state_d.sys_p = sys_prob;
            state_d.par_p = par_prob;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign gamma_o = state_q.gamma;

    // R6: extrinsic bit gates the opposite information-bit row.
    p_ext_one_r6: assert property (@(posedge clk) disable iff (rst)
        ext_in |=> (gamma_o[1:0] == 2'b00));
    p_ext_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !ext_in |=> (gamma_o[3:2] == 2'b00));
    // R2: stored probabilities hold without start.
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(state_q.sys_p) && $stable(state_q.par_p)));
    // R3: a random value at or above the stored probability silences the 1 row.
    p_rnd_high_r3: assert property (@(posedge clk) disable iff (rst)
        (!start && (rnd_sys >= state_q.sys_p)) |=> (gamma_o[3:2] == 2'b00));
    // R4: at most one information-bit row can be active.
    p_row_limit_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(gamma_o) <= 2);
endmodule

// File: tb/tb_sbm_branch_gen.sv
module tb_sbm_branch_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [6:0] sys_prob = '0, par_prob = '0, rnd_sys = '0, rnd_par = '0;
    logic       ext_in = 1'b0;
    logic [3:0] gamma_o;

    sbm_branch_gen dut (
        .clk(clk), .rst(rst), .start(start), .sys_prob(sys_prob), .par_prob(par_prob),
        .ext_in(ext_in), .rnd_sys(rnd_sys), .rnd_par(rnd_par), .gamma_o(gamma_o)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        int         due;
        logic [3:0] exp_g;
        string      req;
        bit         stat;
    } item_t;

    item_t      sb_q[$];
    int         cyc = 0;
    int         n_chk = 0, n_fail = 0;
    int         ones_cnt [4] = '{0, 0, 0, 0};
    logic [6:0] m_sys = '0, m_par = '0;   // bench model of captured values
    string      cur_req = "R5";
    bit         stat_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: gamma actual %b expected %b at cycle %0d", req, act, exp_v, cyc);
        end
    endtask

    // Driver: one decoding cycle of stimulus plus its expected result.
    task automatic drive(input bit st, input logic [6:0] sp, input logic [6:0] pp,
                         input bit ex, input logic [6:0] rs, input logic [6:0] rp);
        item_t it;
        logic [6:0] es, ep;
        logic [1:0] sv, pv, xv;
        @(negedge clk);
        start = st; sys_prob = sp; par_prob = pp; ext_in = ex; rnd_sys = rs; rnd_par = rp;
        if (st) begin m_sys = sp; m_par = pp; end
        es = m_sys; ep = m_par;
        sv = {rs < es, rs < (7'd127 - es)};
        pv = {rp < ep, rp < (7'd127 - ep)};
        xv = {ex, ~ex};
        for (int j = 0; j < 2; j++)
            for (int k = 0; k < 2; k++)
                it.exp_g[2*j+k] = xv[j] & sv[j] & pv[k];
        it.due  = cyc + 1;
        it.req  = cur_req;
        it.stat = stat_on;
        sb_q.push_back(it);
    endtask

    // Monitor: compare the output produced at the edge each item was due.
    always @(negedge clk) begin
        #1;
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            it = sb_q.pop_front();
            chk(it.req, gamma_o, it.exp_g);
            if (it.stat)
                for (int b = 0; b < 4; b++) ones_cnt[b] += int'(gamma_o[b]);
        end
    end

    task automatic stat_check(input int b, input real pj, input real pk);
        real mean, tol;
        mean = 0.5 * pj * pk * 4096.0;
        tol  = 6.0 * $sqrt(mean) + 8.0;
        n_chk++;
        if ($itor(ones_cnt[b]) > mean + tol || $itor(ones_cnt[b]) < mean - tol) begin
            n_fail++;
            $display("FAIL R8: branch %0d ones actual %0d expected %0d", b, ones_cnt[b], $rtoi(mean));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset holds outputs at zero even with active-looking stimulus
        @(negedge clk);
        sys_prob = 7'd100; par_prob = 7'd100; start = 1'b1; ext_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", gamma_o, 4'b0000);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        // R1: stored probabilities reset to 0, so a 1-stream cannot fire
        cur_req = "R1";
        drive(1'b0, 7'd100, 7'd100, 1'b1, 7'd0, 7'd0);   // sys 0: value0 stream r<127 ->1; ext=1 selects row 1 -> 0
        drive(1'b0, 7'd100, 7'd100, 1'b0, 7'd0, 7'd0);   // row 0: sys0=1, par0=1 -> gamma00
        // R5: start uses new probabilities on the same edge
        cur_req = "R5";
        drive(1'b1, 7'd100, 7'd30, 1'b1, 7'd50, 7'd10);  // expect gamma11
        drive(1'b0, 7'd0, 7'd0, 1'b1, 7'd50, 7'd40);     // expect gamma10 (R2 hold too)
        // R3/R4: randomized streams over held probabilities
        cur_req = "R4";
        for (int i = 0; i < 200; i++)
            drive(1'b0, 7'($urandom), 7'($urandom), 1'($urandom), 7'($urandom), 7'($urandom));
        cur_req = "R3";
        drive(1'b0, 7'd5, 7'd5, 1'b1, 7'd99, 7'd29);     // r just below p: ones
        drive(1'b0, 7'd5, 7'd5, 1'b1, 7'd100, 7'd30);    // r equal p: no ones
        drive(1'b0, 7'd5, 7'd5, 1'b0, 7'd26, 7'd96);     // 127-100=27, 127-30=97: both zero-streams 1
        drive(1'b0, 7'd5, 7'd5, 1'b0, 7'd27, 7'd97);
        // R2: new probabilities without start are ignored
        cur_req = "R2";
        for (int i = 0; i < 20; i++)
            drive(1'b0, 7'($urandom), 7'($urandom), 1'($urandom), 7'($urandom), 7'($urandom));
        // R7: boundaries 0 and 127
        cur_req = "R7";
        drive(1'b1, 7'd0, 7'd127, 1'b1, 7'd0, 7'd126);
        for (int r = 0; r < 128; r += 7)
            drive(1'b0, 7'd0, 7'd127, 1'($urandom), 7'(r), 7'(127 - r));
        drive(1'b1, 7'd127, 7'd0, 1'b0, 7'd0, 7'd0);
        drive(1'b0, 7'd127, 7'd0, 1'b1, 7'd126, 7'd127);
        drive(1'b0, 7'd127, 7'd0, 1'b1, 7'd127, 7'd0);
        // R8: long-run ones counts against product of probabilities
        cur_req = "R8";
        drive(1'b1, 7'd96, 7'd32, 1'b0, 7'd0, 7'd0);
        stat_on = 1'b1;
        for (int i = 0; i < 4096; i++)
            drive(1'b0, 7'd96, 7'd32, (7'($urandom) < 7'd64), 7'($urandom), 7'($urandom));
        stat_on = 1'b0;
        drive(1'b0, 7'd96, 7'd32, 1'b0, 7'd127, 7'd127);
        repeat (3) @(negedge clk);
        stat_check(0, 31.0 / 128.0, 95.0 / 128.0);
        stat_check(1, 31.0 / 128.0, 32.0 / 128.0);
        stat_check(2, 96.0 / 128.0, 95.0 / 128.0);
        stat_check(3, 96.0 / 128.0, 32.0 / 128.0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule